// File: doc/BRIEF.md
# Multi-Channel Frame-Number Aligner

A parallel video link splits one large picture into several HD-sized tiles. Each tile goes through its own encoder, network path and decoder, so the decoded tiles reach the display side with different delays. Each decoded tile carries a 4-bit frame number written into one picture row. A mark detector upstream of this block recovers that number.

This block receives up to eight such decoded pixel streams, each paired with its detected frame number. It buffers every channel in a small ring of whole-frame slots and waits until every enabled channel holds a frame with the same number. It then replays those frames on all channels in lock-step, with the marked row replaced on the way out. Older frames that can never be matched are thrown away. A channel that runs too far ahead loses its oldest frame and raises an overflow pulse.

The frame store is modelled as on-chip slot buffers with a tiny frame size (FW x FH pixels). The controller is a three-state machine:
- WAIT: looks at the head of every enabled ring.
- TRIM: discards stale heads for one cycle.
- PLAY: streams one aligned frame.

The transitions are:
- WAIT to TRIM when all enabled heads exist but disagree.
- WAIT to PLAY when they all agree.
- TRIM to WAIT always.
- PLAY to WAIT after the last pixel.

Top module: `frame_aligner`

## Requirements
- R1: While reset is asserted and right after it, `out_valid`, `out_sof` and every bit of `ovf_flag` are 0.
- R2: A frame is released only when every enabled channel holds a complete frame with the same tag. All enabled channels then output that frame together under one shared `out_valid`. Rows other than the mark row carry the stored pixels unchanged, in raster order.
- R3: The tag is taken from `in_tag` on the first pixel of each frame. The released tag, shown on `out_tag` during the frame, is the oldest one held by every enabled channel. A head frame whose tag is older than the head of any other enabled channel is discarded. The release sequence is therefore the tags common to all enabled channels, in arrival order.
- R4: A channel may buffer up to DEPTH (8) complete frames ahead of the others without any overflow pulse and without losing a frame.
- R5: When a channel completes a frame while it already holds DEPTH frames, its oldest frame is dropped. Its `ovf_flag` bit pulses high for exactly one cycle per dropped frame.
- R6: With `fill_copy` = 0, every pixel of row MARK_ROW (row 0 by default) is output as BLACK (0).
- R7: With `fill_copy` = 1, row MARK_ROW is output as a copy of row MARK_ROW+1 of the same frame. When MARK_ROW is the last row, the copy comes from row MARK_ROW-1.
- R8: Output starts only at a frame boundary. `out_sof` is high on the first pixel of each released frame. `out_valid` then stays high for exactly FW*FH consecutive cycles.
- R9: Tags are compared modulo 16. Tag b is newer than tag a when (b - a) mod 16 lies in 1..8, so a sequence such as 14, 15, 0, 1 is aligned and released in order.
- R10: A channel whose `chan_en` bit is 0 ignores its inputs. It never raises `ovf_flag`, and it outputs 0 pixels during releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | NCH | Per-channel enable, static between resets |
| fill_copy | input | 1 | Mark-row replacement: 0 black, 1 adjacent row |
| in_valid | input | NCH | Per-channel pixel strobe |
| in_pix | input | NCH*PW | Per-channel pixel, channel c at bits [c*PW +: PW] |
| in_tag | input | NCH*4 | Per-channel detected tag, sampled on a frame's first pixel |
| out_valid | output | 1 | Aligned pixel valid on all channels |
| out_sof | output | 1 | First pixel of a released frame |
| out_tag | output | 4 | Tag of the frame being released |
| out_pix | output | NCH*PW | Aligned pixels, channel c at bits [c*PW +: PW] |
| ovf_flag | output | NCH | One-cycle pulse per frame dropped by overflow |

## Verification
The assertions rest on these assumptions:
- `chan_en` and `fill_copy` stay constant between resets.
- Each channel's tags advance in arrival order.
- At any moment, the buffered heads of the enabled channels lie within eight frames of each other, so the modulo comparison is never ambiguous.

The stimulus follows these assumptions. Every scenario starts from a reset. The random scenarios run one increasing frame index (wrapping mod 16) through all channels. Isolated frames are omitted at random. Start offsets and pixel duty cycles are bounded so that no channel gets more than about five frames ahead. Overflow is produced only by the directed scenario, in which the other channel is deliberately held empty.

// File: rtl/fa_pkg.sv
package fa_pkg;
    localparam int TAG_W = 4;
    localparam int TAG_WIN = 2 ** (TAG_W - 1);

    typedef enum logic [1:0] {
        S_WAIT,
        S_TRIM,
        S_PLAY
    } fa_state_e;

    // b is newer than a when the modulo distance lies inside the window
    function automatic logic tag_newer(input logic [TAG_W-1:0] b, input logic [TAG_W-1:0] a);
        logic [TAG_W-1:0] d;
        d = b - a;
        return (d != '0) && (int'(d) <= TAG_WIN);
    endfunction
endpackage

// File: rtl/fa_slot_ring.sv
module fa_slot_ring
    import fa_pkg::*;
#(
    parameter int PW    = 8,
    parameter int FP    = 12,
    parameter int DEPTH = 8,
    localparam int SLOTS = DEPTH + 1,
    localparam int SW    = $clog2(SLOTS),
    localparam int IW    = (FP > 1) ? $clog2(FP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             in_valid,
    input  logic [PW-1:0]    in_pix,
    input  logic [TAG_W-1:0] in_tag,
    input  logic             pop,
    input  logic [SW-1:0]    rd_slot,
    input  logic [IW-1:0]    rd_idx,
    output logic [PW-1:0]    rd_pix,
    output logic [SW-1:0]    head_slot,
    output logic [TAG_W-1:0] head_tag,
    output logic             nonempty,
    output logic             ovf
);
    localparam int AW = $clog2(SLOTS * FP);
    localparam int CW = $clog2(DEPTH + 1);

    logic [PW-1:0]    mem  [SLOTS*FP];
    logic [TAG_W-1:0] tags [SLOTS];
    logic [SW-1:0]    wr_slot, rd_ptr;
    logic [IW-1:0]    wr_idx;
    logic [CW-1:0]    count;
    logic             take, last, pop_eff;
    logic [AW-1:0]    wa, ra;

    function automatic logic [SW-1:0] nxt(input logic [SW-1:0] s);
        return (s == SW'(SLOTS - 1)) ? '0 : s + 1'b1;
    endfunction

    assign take     = en & in_valid;
    assign last     = take && (wr_idx == IW'(FP - 1));
    assign ovf      = last && (count == CW'(DEPTH));
    assign pop_eff  = pop | ovf;
    assign wa       = AW'(wr_slot) * AW'(FP) + AW'(wr_idx);
    assign ra       = AW'(rd_slot) * AW'(FP) + AW'(rd_idx);
    assign rd_pix   = mem[ra];
    assign head_slot = rd_ptr;
    assign head_tag = tags[rd_ptr];
    assign nonempty = (count != '0);

    always_ff @(posedge clk) begin
        if (take) begin
            mem[wa] <= in_pix;
            if (wr_idx == '0) tags[wr_slot] <= in_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx  <= '0;
            wr_slot <= '0;
            rd_ptr  <= '0;
            count   <= '0;
        end else begin
            if (take) wr_idx <= last ? '0 : wr_idx + 1'b1;
            if (last) wr_slot <= nxt(wr_slot);
            if (pop_eff) rd_ptr <= nxt(rd_ptr);
            unique case ({last, pop_eff})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_depth_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH);
    assert_ovf_keeps_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (count == CW'(DEPTH)));
    assert_pop_needs_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> nonempty);
endmodule

// File: rtl/fa_mark_map.sv
module fa_mark_map #(
    parameter int FW       = 4,
    parameter int FH       = 3,
    parameter int MARK_ROW = 0,
    localparam int FP  = FW * FH,
    localparam int IW  = (FP > 1) ? $clog2(FP) : 1,
    localparam int ADJ = (MARK_ROW == FH - 1) ? MARK_ROW - 1 : MARK_ROW + 1
) (
    input  logic          fill_copy,
    input  logic [IW-1:0] pidx,
    output logic [IW-1:0] src_idx,
    output logic          blank
);
    int row, col;

    always_comb begin
        row     = int'(pidx) / FW;
        col     = int'(pidx) % FW;
        src_idx = pidx;
        blank   = 1'b0;
        if (row == MARK_ROW) begin
            if (fill_copy) src_idx = IW'(ADJ * FW + col);
            else           blank   = 1'b1;
        end
    end
endmodule

// File: rtl/frame_aligner.sv
module frame_aligner
    import fa_pkg::*;
#(
    parameter int NCH      = 8,
    parameter int PW       = 8,
    parameter int FW       = 4,
    parameter int FH       = 3,
    parameter int DEPTH    = 8,
    parameter int MARK_ROW = 0,
    parameter logic [PW-1:0] BLACK = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCH-1:0]     chan_en,
    input  logic               fill_copy,
    input  logic [NCH-1:0]     in_valid,
    input  logic [NCH*PW-1:0]  in_pix,
    input  logic [NCH*TAG_W-1:0] in_tag,
    output logic               out_valid,
    output logic               out_sof,
    output logic [TAG_W-1:0]   out_tag,
    output logic [NCH*PW-1:0]  out_pix,
    output logic [NCH-1:0]     ovf_flag
);
    localparam int FP = FW * FH;
    localparam int IW = (FP > 1) ? $clog2(FP) : 1;
    localparam int SW = $clog2(DEPTH + 1);

    fa_state_e        state, state_n;
    logic [IW-1:0]    pidx, src_idx;
    logic             blank;
    logic [NCH-1:0]   nonempty, ovf, pop, older, skip;
    logic [TAG_W-1:0] head_tag [NCH];
    logic [SW-1:0]    head_slot [NCH];
    logic [SW-1:0]    play_slot [NCH];
    logic [PW-1:0]    rd_pix [NCH];
    logic [TAG_W-1:0] ref_tag, rel_tag;
    logic             ready, last_pix;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        fa_slot_ring #(.PW(PW), .FP(FP), .DEPTH(DEPTH)) u_ring (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (chan_en[c]),
            .in_valid (in_valid[c]),
            .in_pix   (in_pix[c*PW +: PW]),
            .in_tag   (in_tag[c*TAG_W +: TAG_W]),
            .pop      (pop[c]),
            .rd_slot  (play_slot[c]),
            .rd_idx   (src_idx),
            .rd_pix   (rd_pix[c]),
            .head_slot(head_slot[c]),
            .head_tag (head_tag[c]),
            .nonempty (nonempty[c]),
            .ovf      (ovf[c])
        );
    end

    fa_mark_map #(.FW(FW), .FH(FH), .MARK_ROW(MARK_ROW)) u_map (
        .fill_copy(fill_copy),
        .pidx     (pidx),
        .src_idx  (src_idx),
        .blank    (blank)
    );

    // pairwise age comparison of the enabled heads
    always_comb begin
        older   = '0;
        ref_tag = '0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (chan_en[c]) ref_tag = head_tag[c];
            for (int d = 0; d < NCH; d++) begin
                if (chan_en[c] && nonempty[c] && chan_en[d] && nonempty[d] &&
                    tag_newer(head_tag[d], head_tag[c]))
                    older[c] = 1'b1;
            end
        end
    end

    assign ready    = (|chan_en) && (&(nonempty | ~chan_en));
    assign last_pix = (pidx == IW'(FP - 1));

    always_comb begin
        state_n = state;
        pop     = '0;
        unique case (state)
            S_WAIT: if (ready) state_n = (|older) ? S_TRIM : S_PLAY;
            S_TRIM: begin
                pop     = older;
                state_n = S_WAIT;
            end
            S_PLAY: if (last_pix) begin
                pop     = chan_en & ~skip;
                state_n = S_WAIT;
            end
            default: state_n = S_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_WAIT;
        else        state <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pidx    <= '0;
            skip    <= '0;
            rel_tag <= '0;
            for (int c = 0; c < NCH; c++) play_slot[c] <= '0;
        end else if (state == S_WAIT && state_n == S_PLAY) begin
            pidx    <= '0;
            skip    <= ovf;
            rel_tag <= ref_tag;
            for (int c = 0; c < NCH; c++) play_slot[c] <= head_slot[c];
        end else if (state == S_PLAY) begin
            pidx <= last_pix ? '0 : pidx + 1'b1;
            skip <= skip | ovf;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_tag   <= '0;
            out_pix   <= '0;
            ovf_flag  <= '0;
        end else begin
            out_valid <= (state == S_PLAY);
            out_sof   <= (state == S_PLAY) && (pidx == '0);
            out_tag   <= rel_tag;
            ovf_flag  <= ovf & chan_en;
            for (int c = 0; c < NCH; c++)
                out_pix[c*PW +: PW] <= !chan_en[c] ? '0 : (blank ? BLACK : rd_pix[c]);
        end
    end

    assert_trim_returns_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_TRIM) |=> (state == S_WAIT));
    assert_play_has_frames_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PLAY) |-> (&(nonempty | ~chan_en)));
    assert_sof_then_body_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |=> (out_valid && !out_sof));
    assert_valid_from_play_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(state) == S_PLAY));
endmodule

// File: tb/frame_aligner_bench.sv
module frame_aligner_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;
    localparam int PW = 8;
    localparam int FW = 4;
    localparam int FH = 3;
    localparam int FP = FW * FH;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    chan_en = '0;
    logic              fill_copy = 1'b0;
    logic [NCH-1:0]    in_valid = '0;
    logic [NCH*PW-1:0] in_pix = '0;
    logic [NCH*4-1:0]  in_tag = '0;
    logic              out_valid, out_sof;
    logic [3:0]        out_tag;
    logic [NCH*PW-1:0] out_pix;
    logic [NCH-1:0]    ovf_flag;

    frame_aligner u_frame_aligner (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .fill_copy(fill_copy),
        .in_valid(in_valid), .in_pix(in_pix), .in_tag(in_tag),
        .out_valid(out_valid), .out_sof(out_sof), .out_tag(out_tag),
        .out_pix(out_pix), .ovf_flag(ovf_flag)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int errors = 0;
    int checks = 0;
    int seqj [NCH][40];
    int nfr [NCH];
    int start [NCH];
    int duty [NCH];
    int exp_ovf [NCH];
    int ovf_cnt [NCH];
    int exp_j [64];
    int exp_n, rel_k, pi;
    logic [PW-1:0] cap [NCH][FP];
    logic [3:0] cap_tag;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic logic [PW-1:0] pv(input int j, input int pos);
        return PW'(((j % 16) << 4) | pos);
    endfunction

    function automatic bit has(input int c, input int j);
        for (int k = 0; k < nfr[c]; k++) if (seqj[c][k] == j) return 1'b1;
        return 1'b0;
    endfunction

    // tags common to all enabled channels, in arrival order
    task automatic build_expected();
        int r;
        bit ok;
        r = -1;
        for (int c = NCH - 1; c >= 0; c--) if (chan_en[c]) r = c;
        exp_n = 0;
        for (int k = 0; k < nfr[r]; k++) begin
            ok = 1'b1;
            for (int c = 0; c < NCH; c++)
                if (chan_en[c] && !has(c, seqj[r][k])) ok = 1'b0;
            if (ok) begin
                exp_j[exp_n] = seqj[r][k];
                exp_n++;
            end
        end
    endtask

    task automatic check_frame();
        int j, bad_body, bad_mark, bad_off;
        logic [PW-1:0] e;
        if (rel_k >= exp_n) begin
            chk(1'b0, "R3", "unexpected extra release", rel_k, exp_n);
            return;
        end
        j = exp_j[rel_k];
        chk(cap_tag == 4'(j % 16), "R3", "released tag", cap_tag, j % 16);
        for (int c = 0; c < NCH; c++) begin
            bad_body = 0; bad_mark = 0; bad_off = 0;
            for (int i = 0; i < FP; i++) begin
                if (!chan_en[c]) begin
                    if (cap[c][i] != '0) bad_off++;
                end else if (i / FW == 0) begin
                    e = fill_copy ? pv(j, FW + i % FW) : '0;
                    if (cap[c][i] != e) bad_mark++;
                end else if (cap[c][i] != pv(j, i)) bad_body++;
            end
            if (!chan_en[c])
                chk(bad_off == 0, "R10", "disabled channel pixels nonzero", bad_off, 0);
            else begin
                chk(bad_body == 0, "R2", "aligned body pixel mismatches", bad_body, 0);
                if (fill_copy)
                    chk(bad_mark == 0, "R7", "mark row copy mismatches", bad_mark, 0);
                else
                    chk(bad_mark == 0, "R6", "mark row black mismatches", bad_mark, 0);
            end
        end
        rel_k++;
    endtask

    always @(negedge clk) begin
        if (!rst_n) pi = 0;
        else begin
            for (int c = 0; c < NCH; c++) if (ovf_flag[c]) ovf_cnt[c]++;
            if (out_valid) begin
                if (pi == 0 && !out_sof) chk(1'b0, "R8", "frame start without sof", 0, 1);
                if (pi != 0 && out_sof) chk(1'b0, "R8", "sof inside frame", pi, 0);
                if (pi == 0) cap_tag = out_tag;
                for (int c = 0; c < NCH; c++) cap[c][pi] = out_pix[c*PW +: PW];
                pi++;
                if (pi == FP) begin
                    check_frame();
                    pi = 0;
                end
            end else if (pi != 0) begin
                chk(1'b0, "R8", "valid dropped inside frame", pi, FP);
                pi = 0;
            end
        end
    end

    task automatic clear_cfg();
        for (int c = 0; c < NCH; c++) begin
            nfr[c] = 0; start[c] = 0; duty[c] = 100; exp_ovf[c] = 0;
        end
    endtask

    task automatic run_scenario(input string req_ovf);
        int fidx [NCH];
        int pidx [NCH];
        int cyc;
        bit busy;
        build_expected();
        rst_n = 1'b0;
        in_valid = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0 && out_sof == 1'b0 && ovf_flag == '0, "R1",
            "outputs during reset", int'(out_valid) + int'(ovf_flag), 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        for (int c = 0; c < NCH; c++) begin
            fidx[c] = 0; pidx[c] = 0; ovf_cnt[c] = 0;
        end
        rel_k = 0;
        @(negedge clk);
        chk(out_valid == 1'b0 && ovf_flag == '0, "R1", "outputs after reset",
            int'(out_valid), 0);
        cyc = 0;
        busy = 1'b1;
        while (busy) begin
            @(posedge clk);
            #1;
            busy = 1'b0;
            for (int c = 0; c < NCH; c++) begin
                in_valid[c] = 1'b0;
                if (fidx[c] < nfr[c]) begin
                    busy = 1'b1;
                    if (cyc >= start[c] && int'($urandom % 100) < duty[c]) begin
                        in_valid[c] = 1'b1;
                        in_pix[c*PW +: PW] = pv(seqj[c][fidx[c]], pidx[c]);
                        in_tag[c*4 +: 4] = 4'(seqj[c][fidx[c]] % 16);
                        pidx[c]++;
                        if (pidx[c] == FP) begin
                            pidx[c] = 0;
                            fidx[c]++;
                        end
                    end
                end
            end
            cyc++;
        end
        @(posedge clk);
        #1 in_valid = '0;
        repeat (400) @(posedge clk);
        @(negedge clk);
        chk(rel_k == exp_n, "R3", "number of released frames", rel_k, exp_n);
        for (int c = 0; c < NCH; c++)
            chk(ovf_cnt[c] == exp_ovf[c], req_ovf, "overflow pulses", ovf_cnt[c], exp_ovf[c]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R2", "watchdog expired", 0, 1);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int k;
        bit prev;
        void'($urandom(32'd2718));

        // R4: channel 0 runs eight frames ahead, nothing lost
        clear_cfg();
        chan_en = 8'b0000_0011; fill_copy = 1'b0;
        nfr[0] = 8; nfr[1] = 8; start[1] = 150;
        for (int i = 0; i < 8; i++) begin seqj[0][i] = i; seqj[1][i] = i; end
        run_scenario("R4");

        // R5: ten frames into a lone channel, two oldest dropped
        clear_cfg();
        chan_en = 8'b0000_0011;
        nfr[0] = 10; nfr[1] = 8; start[1] = 200; exp_ovf[0] = 2;
        for (int i = 0; i < 10; i++) seqj[0][i] = i;
        for (int i = 0; i < 8; i++) seqj[1][i] = i + 2;
        run_scenario("R5");

        // R9: wraparound 13..2 against 15,0,2 with copy fill (R7)
        clear_cfg();
        chan_en = 8'b0000_0011; fill_copy = 1'b1;
        nfr[0] = 6; nfr[1] = 3; start[1] = 5; duty[1] = 60;
        for (int i = 0; i < 6; i++) seqj[0][i] = 13 + i;
        seqj[1][0] = 15; seqj[1][1] = 16; seqj[1][2] = 18;
        run_scenario("R9");

        // R10: middle channel disabled and flooded
        clear_cfg();
        chan_en = 8'b0000_0101; fill_copy = 1'b1;
        nfr[0] = 6; nfr[1] = 10; nfr[2] = 5; start[2] = 20; duty[2] = 70;
        for (int i = 0; i < 6; i++) seqj[0][i] = i;
        for (int i = 0; i < 10; i++) seqj[1][i] = 20 + i;
        seqj[2][0] = 0; seqj[2][1] = 1; seqj[2][2] = 2; seqj[2][3] = 4; seqj[2][4] = 5;
        run_scenario("R10");

        // R2/R3 random: all channels, omitted frames, lags, both fills
        for (int pass = 0; pass < 2; pass++) begin
            clear_cfg();
            chan_en = 8'hFF; fill_copy = pass[0];
            for (int c = 0; c < NCH; c++) begin
                start[c] = int'($urandom % 15);
                duty[c] = 85 + int'($urandom % 16);
                k = 0; prev = 1'b0;
                for (int j = 0; j < 20; j++) begin
                    if (j > 0 && j < 19 && !prev && ($urandom % 100) < 15) prev = 1'b1;
                    else begin
                        seqj[c][k] = j; k++; prev = 1'b0;
                    end
                end
                nfr[c] = k;
            end
            run_scenario("R4");
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule